// File: doc/BRIEF.md
# Programmable Prescaled Down-Counter Timer

A memory-mapped countdown timer driven through a small word-addressed register port (valid, write, address, data). A control register picks the counting mode (free-running, periodic or one-shot), the counter width (16 or 32 bits) and a clock prescale of 1, 16 or 256. When the counter steps from one to zero it raises a sticky raw interrupt flag. The level interrupt output is that flag gated by an enable bit. Software clears the flag by writing to a dedicated clear offset.

Two offsets hold the same reload value. A write to the immediate offset stores the value and reloads the counter at once. A write to the background offset stores it silently, so the running count only picks it up at the next wrap. In free-running mode the counter ignores the stored value and reloads from the all-ones value of the selected width.

Top module: `pdc_timer`

## Requirements
- R1: After reset, control reads 0x20 (interrupt enable set, timer disabled, free-running, 16-bit, divide by 1). The count value, raw status and irq are all 0.
- R2: The prescaler is a free-running divider. Control bits 3:2 set to 01 give one count tick every 16 clocks; 10 gives one every 256 clocks; 00 and 11 give a tick on every clock.
- R3: The counter changes only on a tick while control bit 7 (enable) is 1. A nonzero count then drops by exactly one.
- R4: Control bit 1 set to 1 selects a 32-bit count; 0 selects 16 bits. In 16-bit mode the value offset reads with bits 31:16 zero, and loaded values are truncated to 16 bits.
- R5: With control bit 6 (periodic) or bit 0 (one-shot) set, the reload source is the stored reload value. In periodic mode a tick at zero reloads the counter, so one period is reload+1 ticks.
- R6: With control bit 0 (one-shot) set, the counter holds at zero on later ticks until it is reloaded.
- R7: With bits 6 and 0 both clear (free-running), every reload uses 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, whatever the stored value.
- R8: irq equals the raw flag AND control bit 5. Offset 4 reads the raw flag in bit 0. Offset 5 reads raw AND bit 5.
- R9: A tick that moves the count from 1 to 0 sets the raw flag. Any write to offset 3 clears it. If both happen in the same cycle, the set wins.
- R10: A write to offset 0 stores the value and reloads the counter in that same cycle from the mode's reload source. A write to control (offset 2) with bit 7 set also reloads, using the new mode.
- R11: A write to offset 6 stores the reload value without touching the count, and the next reload uses it. Reads of offsets 0 and 6 both return the stored value.
- R12: Writes to offset 1 (value) and to undefined offsets (7 and up) change nothing. Reads of undefined offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, combinational, 0 when idle |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: a 32-bit counter, a 16-bit narrow mode, a 4-bit offset and prescale shifts of 4 and 8. With these values the divide-by-256 path wraps several times within a couple of thousand cycles, and offsets 7 to 15 can be used to probe undefined addresses. The 32-bit all-ones reload is seen through a read after a load, not through a full wrap.

// File: rtl/pdc_timer_pkg.sv
package pdc_timer_pkg;

    localparam int OFS_LOAD   = 0;
    localparam int OFS_VALUE  = 1;
    localparam int OFS_CTRL   = 2;
    localparam int OFS_ICLR   = 3;
    localparam int OFS_RAW    = 4;
    localparam int OFS_MASKED = 5;
    localparam int OFS_BGLOAD = 6;

    localparam logic [1:0] DIV_SEL_A = 2'b01;
    localparam logic [1:0] DIV_SEL_B = 2'b10;

    typedef struct packed {
        logic       run;
        logic       periodic;
        logic       irq_en;
        logic       spare;
        logic [1:0] div_sel;
        logic       wide;
        logic       single;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{run: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                     spare: 1'b0, div_sel: 2'b00, wide: 1'b0,
                                     single: 1'b0};

endpackage

// File: rtl/pdc_prescaler.sv
module pdc_prescaler #(
    parameter int A_LOG = 4,
    parameter int B_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    output logic       tick_o
);
    import pdc_timer_pkg::*;

    localparam int PW = (B_LOG > A_LOG) ? B_LOG : A_LOG;

    logic [PW-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + PW'(1);
        case (div_sel)
            DIV_SEL_A: tick_o = (div_q[A_LOG-1:0] == {A_LOG{1'b1}});
            DIV_SEL_B: tick_o = (div_q[B_LOG-1:0] == {B_LOG{1'b1}});
            default:   tick_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

endmodule

// File: rtl/pdc_counter.sv
module pdc_counter #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             wide,
    input  logic             single,
    input  logic             load_now,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] count_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] NARROW_MASK =
        {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic [CNT_W-1:0] cur;

    always_comb begin
        cur     = st_q.count & (wide ? {CNT_W{1'b1}} : NARROW_MASK);
        st_d    = st_q;
        hit_o   = 1'b0;
        st_d.count = cur;
        if (load_now) begin
            st_d.count = reload_val;
        end else if (run && tick) begin
            if (cur == '0) begin
                st_d.count = single ? '0 : reload_val;
            end else begin
                st_d.count = cur - CNT_W'(1);
                hit_o      = (cur == CNT_W'(1));
            end
        end
        count_o = cur;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pdc_timer.sv
module pdc_timer #(
    parameter int CNT_W     = 32,
    parameter int NARROW_W  = 16,
    parameter int ADDR_W    = 4,
    parameter int DIV_A_LOG = 4,
    parameter int DIV_B_LOG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);
    import pdc_timer_pkg::*;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam logic [CNT_W-1:0] NARROW_MASK =
        {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] limit;
        logic             raw;
    } regs_t;

    regs_t st_d, st_q;

    logic             wr_load, wr_ctrl, wr_iclr, wr_bg, rd_en;
    ctrl_t            ctrl_nx;
    logic [CNT_W-1:0] limit_nx, nx_mask, reload_val, count_val;
    logic             load_now, tick, hit;
    logic [7:0]       ctrl_bits;
    logic             raw_bit;

    // Access decode and reload-source selection from the post-write config.
    always_comb begin
        rd_en   = bus_valid && !bus_write;
        wr_load = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_LOAD));
        wr_ctrl = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_iclr = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_ICLR));
        wr_bg   = bus_valid && bus_write && (bus_addr == ADDR_W'(OFS_BGLOAD));
        ctrl_nx  = wr_ctrl ? ctrl_t'(bus_wdata[CTRL_W-1:0]) : st_q.ctrl;
        limit_nx = (wr_load || wr_bg) ? bus_wdata : st_q.limit;
        nx_mask  = ctrl_nx.wide ? {CNT_W{1'b1}} : NARROW_MASK;
        reload_val = (ctrl_nx.periodic || ctrl_nx.single) ? (limit_nx & nx_mask)
                                                          : nx_mask;
        load_now = wr_load || (wr_ctrl && ctrl_nx.run);
    end

    // Next-state for the register file.
    always_comb begin
        st_d       = st_q;
        st_d.ctrl  = ctrl_nx;
        st_d.limit = limit_nx;
        if (hit)          st_d.raw = 1'b1;
        else if (wr_iclr) st_d.raw = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctrl  <= CTRL_RESET;
            st_q.limit <= '0;
            st_q.raw   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    pdc_prescaler #(.A_LOG(DIV_A_LOG), .B_LOG(DIV_B_LOG)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (st_q.ctrl.div_sel),
        .tick_o  (tick)
    );

    pdc_counter #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (st_q.ctrl.run),
        .tick       (tick),
        .wide       (st_q.ctrl.wide),
        .single     (st_q.ctrl.single),
        .load_now   (load_now),
        .reload_val (reload_val),
        .count_o    (count_val),
        .hit_o      (hit)
    );

    always_comb begin
        ctrl_bits = st_q.ctrl;
        raw_bit   = st_q.raw;
        irq       = st_q.raw && st_q.ctrl.irq_en;
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                ADDR_W'(OFS_LOAD),
                ADDR_W'(OFS_BGLOAD): bus_rdata = st_q.limit;
                ADDR_W'(OFS_VALUE):  bus_rdata = count_val;
                ADDR_W'(OFS_CTRL):   bus_rdata = CNT_W'(ctrl_bits);
                ADDR_W'(OFS_RAW):    bus_rdata = CNT_W'(st_q.raw);
                ADDR_W'(OFS_MASKED): bus_rdata = CNT_W'(irq);
                default:             bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pdc_timer_chk.sv
module pdc_timer_chk #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             single,
    input logic             wide,
    input logic [1:0]       div_sel,
    input logic             tick,
    input logic             hit,
    input logic             load_now,
    input logic             ctrl_wr,
    input logic             iclr_wr,
    input logic             raw,
    input logic             irq,
    input logic [CNT_W-1:0] count
);

    a_r6_oneshot_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run && single && count == '0 && !load_now) |=> (count == '0));

    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_now && !ctrl_wr) |=> $stable(count));

    a_r9_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> raw);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (iclr_wr && !hit) |=> !raw);

    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hit) || $past(ctrl_wr)));

    a_r4_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> ((count >> NARROW_W) == '0));

    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (div_sel == 2'b01 || div_sel == 2'b10) && !ctrl_wr) |=> !tick);

endmodule

bind pdc_timer pdc_timer_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl_bits[7]),
    .single   (ctrl_bits[0]),
    .wide     (ctrl_bits[1]),
    .div_sel  (ctrl_bits[3:2]),
    .tick     (tick),
    .hit      (hit),
    .load_now (load_now),
    .ctrl_wr  (wr_ctrl),
    .iclr_wr  (wr_iclr),
    .raw      (raw_bit),
    .irq      (irq),
    .count    (count_val)
);

// File: tb/tb_pdc_timer.sv
`timescale 1ns/1ps
module tb_pdc_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        b_valid = 1'b0;
    logic        b_write = 1'b0;
    logic [3:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        done = 1'b0;

    int n_total = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pdc_timer dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (b_valid),
        .bus_write (b_write),
        .bus_addr  (b_addr),
        .bus_wdata (b_wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    // Behavioural reference state
    int          m_pre;
    logic [7:0]  m_ctrl;
    logic [31:0] m_lim;
    logic [31:0] m_cnt;
    logic        m_raw;

    logic [7:0]  t_ctrl;
    logic [31:0] t_lim, t_cur, t_mask, t_rel;
    logic        t_tick, t_ld, t_hit, t_wr;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_ctrl = 8'h20; m_lim = 0; m_cnt = 0; m_raw = 0;
        end else begin
            case (m_ctrl[3:2])
                2'b01:   t_tick = (m_pre % 16 == 15);
                2'b10:   t_tick = (m_pre == 255);
                default: t_tick = 1'b1;
            endcase
            t_cur = m_cnt & (m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
            t_wr = b_valid && b_write;
            t_ctrl = m_ctrl; t_lim = m_lim; t_ld = 1'b0; t_hit = 1'b0;
            if (t_wr) begin
                if (b_addr == 0) begin t_lim = b_wdata; t_ld = 1'b1; end
                if (b_addr == 2) begin t_ctrl = b_wdata[7:0]; t_ld = b_wdata[7]; end
                if (b_addr == 6) t_lim = b_wdata;
            end
            t_mask = t_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            t_rel = (t_ctrl[6] || t_ctrl[0]) ? (t_lim & t_mask) : t_mask;
            if (t_ld) m_cnt = t_rel;
            else if (m_ctrl[7] && t_tick) begin
                if (t_cur == 0) m_cnt = m_ctrl[0] ? 32'h0 : t_rel;
                else begin m_cnt = t_cur - 1; t_hit = (t_cur == 1); end
            end else m_cnt = t_cur;
            if (t_hit) m_raw = 1'b1;
            else if (t_wr && b_addr == 3) m_raw = 1'b0;
            m_ctrl = t_ctrl; m_lim = t_lim;
            m_pre = (m_pre + 1) % 256;
        end
    end

    function automatic logic [31:0] model_read(input int a);
        case (a)
            0, 6: return m_lim;
            1:    return m_cnt & (m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF);
            2:    return {24'h0, m_ctrl};
            4:    return {31'h0, m_raw};
            5:    return {31'h0, m_raw & m_ctrl[5]};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_total++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        @(negedge clk);
        b_valid = 1'b1; b_write = 1'b1; b_addr = 4'(a); b_wdata = d;
        @(negedge clk);
        b_valid = 1'b0; b_write = 1'b0;
    endtask

    // Read compared against the reference model
    task automatic rd_model(input int a, input string tag);
        @(negedge clk);
        b_valid = 1'b1; b_write = 1'b0; b_addr = 4'(a);
        #1;
        check(rdata, model_read(a), tag);
        b_valid = 1'b0;
    endtask

    // Read compared against a literal expected value
    task automatic rd_lit(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        b_valid = 1'b1; b_write = 1'b0; b_addr = 4'(a);
        #1;
        check(rdata, exp, tag);
        b_valid = 1'b0;
    endtask

    task automatic watch(input int n, input int every, input string tag);
        for (int i = 0; i < n; i++) begin
            if (i % every == 0) rd_model(1, tag);
            else @(negedge clk);
        end
    endtask

    // R8: irq against the model on every cycle
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) check({31'h0, irq}, {31'h0, m_raw & m_ctrl[5]}, "R8 irq");
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_lit(2, 32'h20, "R1 ctrl");
        rd_lit(1, 32'h0, "R1 value");
        rd_lit(4, 32'h0, "R1 raw");
        check({31'h0, irq}, 32'h0, "R1 irq");

        // R7 free-running reload from max, timer disabled
        do_write(0, 32'h1234);
        rd_lit(1, 32'hFFFF, "R7 free 16-bit");
        do_write(2, 32'h22);
        do_write(0, 32'h1234);
        rd_lit(1, 32'hFFFF_FFFF, "R7 free 32-bit");

        // R4 truncation, R11 background load, disabled periodic
        do_write(2, 32'h40);
        do_write(0, 32'h0001_2345);
        rd_lit(1, 32'h2345, "R4 masked load");
        rd_lit(0, 32'h0001_2345, "R11 load read");
        do_write(6, 32'h77);
        rd_lit(1, 32'h2345, "R11 count untouched");
        rd_lit(6, 32'h77, "R11 bg read");
        rd_lit(0, 32'h77, "R11 load alias");

        // R3 R5 R10 periodic /1
        do_write(0, 32'h5);
        do_write(2, 32'hE2);
        watch(40, 1, "R5 periodic");
        rd_model(4, "R9 raw");
        do_write(3, 32'h0);
        rd_model(4, "R9 cleared");
        // R11 background load while running
        do_write(6, 32'h9);
        watch(40, 1, "R11 bg wrap");
        // R9 clear pressure, set-wins on collision
        for (int i = 0; i < 30; i++) begin
            do_write(3, 32'h1);
            rd_model(4, "R9 collide");
        end
        // R8 interrupt enable off
        do_write(2, 32'hC2);
        watch(20, 2, "R8 ie off");
        rd_model(5, "R8 masked");
        rd_model(4, "R8 raw");
        do_write(2, 32'hE2);
        rd_model(5, "R8 masked on");

        // R6 one-shot
        do_write(3, 32'h0);
        do_write(0, 32'h4);
        do_write(2, 32'hA3);
        watch(30, 3, "R6 oneshot");
        rd_lit(1, 32'h0, "R6 holds zero");
        rd_lit(4, 32'h1, "R6 raw set");
        do_write(3, 32'h0);
        do_write(0, 32'h3);
        watch(12, 1, "R10 reload oneshot");

        // R2 prescaler
        do_write(0, 32'h2);
        do_write(2, 32'hE6);
        watch(200, 5, "R2 div16");
        do_write(0, 32'h1);
        do_write(2, 32'hEA);
        watch(1500, 25, "R2 div256");
        rd_model(4, "R2 raw");
        do_write(0, 32'h3);
        do_write(2, 32'hEE);
        watch(30, 1, "R2 sel11");

        // R7 free-running running
        do_write(2, 32'hA0);
        do_write(0, 32'h10);
        watch(20, 1, "R7 free run");
        do_write(2, 32'hA2);
        watch(10, 1, "R7 free run 32");

        // R12 ignored writes
        do_write(2, 32'h40);
        do_write(0, 32'h55);
        do_write(1, 32'hDEAD);
        rd_lit(1, 32'h55, "R12 value write");
        do_write(8, 32'hFF);
        do_write(15, 32'hFFFF_FFFF);
        do_write(7, 32'h80);
        rd_lit(2, 32'h40, "R12 ctrl intact");
        rd_lit(0, 32'h55, "R12 load intact");
        rd_lit(1, 32'h55, "R12 count intact");
        rd_lit(7, 32'h0, "R12 read 7");
        rd_lit(12, 32'h0, "R12 read 12");
        rd_lit(3, 32'h0, "R12 read clear ofs");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule